// File: doc/BRIEF.md
# Fetch Block Instruction Predecoder

This block looks at a fetch block of 17 consecutive halfwords and decodes all 16 possible 2-byte instruction positions in parallel. For every position it forms the 32-bit raw code that starts there, and it reports the following:

- whether that code is a compressed (16-bit) instruction;
- which kind of control-flow instruction it is, if any;
- whether it links (a call) or pops a link (a return);
- the sign-extended offset from which a branch target is later computed.

It is purely combinational and has no clock or reset.

Because the decoder cannot know on its own whether the block begins on an instruction boundary, it produces two instruction-start vectors side by side. The first assumes position 0 opens an instruction. The second assumes position 0 is the upper half of a 32-bit instruction that began in the previous block. A later stage picks one of the two vectors. Per-position fields are produced for every position whether or not it is a start, so masking also happens downstream.

Top module: `fbpd_predecoder`

## Requirements
- R1: The raw code of slot i equals halfword i+1 placed above halfword i (halfword 0 is frag_i[15:0]).
- R2: Slot i is flagged compressed exactly when bits [1:0] of halfword i differ from 2'b11.
- R3: For a 32-bit code the type is 01 for opcode 1100011, 10 for opcode 1101111, 11 for opcode 1100111, and 00 for every other opcode; is_cfi is set exactly when the type is nonzero.
- R4: For a compressed code the type is 01 for quadrant 01 with funct3 110 or 111, and 10 for quadrant 01 with funct3 101 or 001 (the 001 form only when HAS_CJAL is 1). It is 11 for quadrant 10 with funct3 100, bits [6:2] zero and bits [11:7] nonzero. Every other compressed code is 00.
- R5: A slot is a call when its type is 10 or 11 and its link destination is x1 or x5. That destination is rd = bits [11:7] for 32-bit codes. For the compressed forms it is x1 for funct3 001 and for the bit 12 = 1 register jump, and x0 otherwise.
- R6: A slot is a return when its type is 11, its source register (bits [19:15] for 32-bit, bits [11:7] for compressed) is x1 or x5, and its destination is not x1 or x5.
- R7: For 32-bit codes the offset is the B-type immediate for type 01 and the J-type immediate for type 10, each sign-extended to OFF_W. It is zero for type 11 and for non-control-flow codes.
- R8: For compressed codes the offset is the CB immediate for type 01 and the CJ immediate for type 10, each sign-extended to OFF_W. It is zero otherwise.
- R9: In start vector A, slot 0 is a start. A later slot is a start unless the slot before it is a start holding a 32-bit code.
- R10: Start vector B follows the same rule as vector A except that slot 0 is not a start, which makes slot 1 the first start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| frag_i | input | (SLOTS+1)*16 = 272 | Fetch block halfwords, halfword 0 in the low bits |
| raw_code_o | output | SLOTS*32 = 512 | 32-bit raw code per slot |
| is_rvc_o | output | SLOTS = 16 | Compressed flag per slot |
| cfi_type_o | output | SLOTS*2 = 32 | Control-flow type per slot (00 none, 01 branch, 10 jal, 11 jalr) |
| is_cfi_o | output | SLOTS = 16 | Control-flow flag per slot |
| is_call_o | output | SLOTS = 16 | Call flag per slot |
| is_ret_o | output | SLOTS = 16 | Return flag per slot |
| tgt_off_o | output | SLOTS*OFF_W = 1024 | Sign-extended target offset per slot |
| start_a_o | output | SLOTS = 16 | Start vector assuming slot 0 begins an instruction |
| start_b_o | output | SLOTS = 16 | Start vector assuming slot 0 is a 32-bit tail |

## Verification
The bench builds the block with its defaults: 16 slots, a 64-bit offset and the compressed jal form enabled. With 16 slots it reaches the last slot, whose 32-bit code draws on the extra 17th halfword. With a 64-bit offset, the sign extension of every immediate kind reaches the top bit. With the compressed jal form enabled, quadrant 01 funct3 001 is exercised as a call. Hand-built blocks of all 32-bit codes give the alternating start patterns, and hand-encoded link and non-link registers separate calls from returns.

// File: rtl/fbpd_pkg.sv
package fbpd_pkg;

   localparam int unsigned HW_W   = 16;
   localparam int unsigned CODE_W = 2 * HW_W;

   typedef enum logic [1:0] {
      CFI_NONE   = 2'b00,
      CFI_BRANCH = 2'b01,
      CFI_JAL    = 2'b10,
      CFI_JALR   = 2'b11
   } cfi_kind_e;

   localparam logic [6:0] OP_BRANCH = 7'b1100011;
   localparam logic [6:0] OP_JAL    = 7'b1101111;
   localparam logic [6:0] OP_JALR   = 7'b1100111;

   localparam logic [1:0] Q_C1 = 2'b01;
   localparam logic [1:0] Q_C2 = 2'b10;

   // Link registers used by the return-address stack convention
   function automatic logic is_link(input logic [4:0] r);
      return (r == 5'd1) || (r == 5'd5);
   endfunction

endpackage

// File: rtl/fbpd_slot_dec.sv
module fbpd_slot_dec
   import fbpd_pkg::*;
#(
   parameter int unsigned OFF_W    = 64,
   parameter bit          HAS_CJAL = 1'b1
) (
   input  logic [CODE_W-1:0] code_i,
   output logic              rvc_o,
   output cfi_kind_e         kind_o,
   output logic              call_o,
   output logic              ret_o,
   output logic [OFF_W-1:0]  off_o
);

   localparam int unsigned IMM_B_W  = 13;
   localparam int unsigned IMM_J_W  = 21;
   localparam int unsigned IMM_CB_W = 9;
   localparam int unsigned IMM_CJ_W = 12;

   if (OFF_W < IMM_J_W) begin : g_off_w_bad
      $error("fbpd_slot_dec: OFF_W must hold a 21-bit jump immediate");
   end

   // ---------------- field extraction ----------------
   logic [6:0] opcode;
   logic [4:0] rvi_rd, rvi_rs1;
   logic [1:0] quad;
   logic [2:0] cf3;
   logic [4:0] c_r1, c_r2;

   assign opcode  = code_i[6:0];
   assign rvi_rd  = code_i[11:7];
   assign rvi_rs1 = code_i[19:15];
   assign quad    = code_i[1:0];
   assign cf3     = code_i[15:13];
   assign c_r1    = code_i[11:7];
   assign c_r2    = code_i[6:2];

   // ---------------- immediates ----------------
   logic [IMM_B_W-1:0]  imm_b;
   logic [IMM_J_W-1:0]  imm_j;
   logic [IMM_CB_W-1:0] imm_cb;
   logic [IMM_CJ_W-1:0] imm_cj;

   assign imm_b  = {code_i[31], code_i[7], code_i[30:25], code_i[11:8], 1'b0};
   assign imm_j  = {code_i[31], code_i[19:12], code_i[20], code_i[30:21], 1'b0};
   assign imm_cb = {code_i[12], code_i[6:5], code_i[2], code_i[11:10],
                    code_i[4:3], 1'b0};
   assign imm_cj = {code_i[12], code_i[8], code_i[10:9], code_i[6], code_i[7],
                    code_i[2], code_i[11], code_i[5:3], 1'b0};

   logic [OFF_W-1:0] sx_b, sx_j, sx_cb, sx_cj;
   assign sx_b  = {{(OFF_W-IMM_B_W){imm_b[IMM_B_W-1]}}, imm_b};
   assign sx_j  = {{(OFF_W-IMM_J_W){imm_j[IMM_J_W-1]}}, imm_j};
   assign sx_cb = {{(OFF_W-IMM_CB_W){imm_cb[IMM_CB_W-1]}}, imm_cb};
   assign sx_cj = {{(OFF_W-IMM_CJ_W){imm_cj[IMM_CJ_W-1]}}, imm_cj};

   // ---------------- compressed jal variant ----------------
   logic cjal_hit;
   if (HAS_CJAL) begin : g_cjal
      assign cjal_hit = (quad == Q_C1) && (cf3 == 3'b001);
   end else begin : g_no_cjal
      assign cjal_hit = 1'b0;
   end

   // ---------------- 32-bit decode ----------------
   cfi_kind_e        w_kind;
   logic             w_call, w_ret;
   logic [OFF_W-1:0] w_off;

   always_comb begin
      w_kind = CFI_NONE;
      w_call = 1'b0;
      w_ret  = 1'b0;
      w_off  = '0;
      unique case (opcode)
         OP_BRANCH: begin
            w_kind = CFI_BRANCH;
            w_off  = sx_b;
         end
         OP_JAL: begin
            w_kind = CFI_JAL;
            w_call = is_link(rvi_rd);
            w_off  = sx_j;
         end
         OP_JALR: begin
            w_kind = CFI_JALR;
            w_call = is_link(rvi_rd);
            w_ret  = is_link(rvi_rs1) && !is_link(rvi_rd);
         end
         default: ;
      endcase
   end

   // ---------------- compressed decode ----------------
   cfi_kind_e        c_kind;
   logic             c_call, c_ret;
   logic [OFF_W-1:0] c_off;
   logic             c_regjump;

   assign c_regjump = (quad == Q_C2) && (cf3 == 3'b100) &&
                      (c_r2 == 5'd0) && (c_r1 != 5'd0);

   always_comb begin
      c_kind = CFI_NONE;
      c_call = 1'b0;
      c_ret  = 1'b0;
      c_off  = '0;
      if ((quad == Q_C1) && (cf3 == 3'b101)) begin
         c_kind = CFI_JAL;
         c_off  = sx_cj;
      end else if (cjal_hit) begin
         c_kind = CFI_JAL;
         c_call = 1'b1;
         c_off  = sx_cj;
      end else if ((quad == Q_C1) && (cf3[2:1] == 2'b11)) begin
         c_kind = CFI_BRANCH;
         c_off  = sx_cb;
      end else if (c_regjump) begin
         c_kind = CFI_JALR;
         if (code_i[12]) begin
            c_call = 1'b1;
         end else begin
            c_ret  = is_link(c_r1);
         end
      end
   end

   // ---------------- output select ----------------
   assign rvc_o  = (quad != 2'b11);
   assign kind_o = rvc_o ? c_kind : w_kind;
   assign call_o = rvc_o ? c_call : w_call;
   assign ret_o  = rvc_o ? c_ret  : w_ret;
   assign off_o  = rvc_o ? c_off  : w_off;

   // ---------------- assertions ----------------
   always_comb begin
      p_call_kind_r5: assert (!call_o || kind_o == CFI_JAL || kind_o == CFI_JALR)
         else $error("call flagged on a slot that is not a jump");
      p_ret_kind_r6: assert (!ret_o || kind_o == CFI_JALR)
         else $error("return flagged on a slot that is not a register jump");
      p_call_ret_excl_r6: assert (!(call_o && ret_o))
         else $error("call and return both flagged");
      p_jalr_off_zero_r7: assert (kind_o != CFI_JALR || off_o == '0)
         else $error("register jump carries a nonzero offset");
      p_none_off_zero_r8: assert (kind_o != CFI_NONE || off_o == '0)
         else $error("non control-flow slot carries a nonzero offset");
   end

endmodule

// File: rtl/fbpd_start_chain.sv
module fbpd_start_chain #(
   parameter int unsigned SLOTS = 16
) (
   input  logic             seed_i,
   input  logic [SLOTS-1:0] rvc_i,
   output logic [SLOTS-1:0] start_o
);

   if (SLOTS < 2) begin : g_slots_bad
      $error("fbpd_start_chain: SLOTS must be at least 2");
   end

   assign start_o[0] = seed_i;

   for (genvar i = 1; i < SLOTS; i++) begin : g_link
      // A slot opens an instruction unless the slot before it opened a 32-bit one
      assign start_o[i] = !(start_o[i-1] && !rvc_i[i-1]);

      always_comb begin
         p_tail_then_start_r9: assert (start_o[i-1] || start_o[i])
            else $error("two consecutive non-start slots at %0d", i);
      end
   end

endmodule

// File: rtl/fbpd_predecoder.sv
module fbpd_predecoder
   import fbpd_pkg::*;
#(
   parameter int unsigned SLOTS    = 16,
   parameter int unsigned OFF_W    = 64,
   parameter bit          HAS_CJAL = 1'b1
) (
   input  logic [(SLOTS+1)*16-1:0] frag_i,
   output logic [SLOTS*32-1:0]     raw_code_o,
   output logic [SLOTS-1:0]        is_rvc_o,
   output logic [SLOTS*2-1:0]      cfi_type_o,
   output logic [SLOTS-1:0]        is_cfi_o,
   output logic [SLOTS-1:0]        is_call_o,
   output logic [SLOTS-1:0]        is_ret_o,
   output logic [SLOTS*OFF_W-1:0]  tgt_off_o,
   output logic [SLOTS-1:0]        start_a_o,
   output logic [SLOTS-1:0]        start_b_o
);

   localparam int unsigned FRAGS = SLOTS + 1;

   if (SLOTS < 2 || SLOTS > 64) begin : g_slots_bad
      $error("fbpd_predecoder: SLOTS must lie in 2..64");
   end

   logic [FRAGS-1:0][HW_W-1:0] hw;
   assign hw = frag_i;

   cfi_kind_e kind [SLOTS];

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [CODE_W-1:0] code;
      assign code = {hw[i+1], hw[i]};
      assign raw_code_o[i*CODE_W +: CODE_W] = code;

      fbpd_slot_dec #(
         .OFF_W    (OFF_W),
         .HAS_CJAL (HAS_CJAL)
      ) u_dec (
         .code_i (code),
         .rvc_o  (is_rvc_o[i]),
         .kind_o (kind[i]),
         .call_o (is_call_o[i]),
         .ret_o  (is_ret_o[i]),
         .off_o  (tgt_off_o[i*OFF_W +: OFF_W])
      );

      assign cfi_type_o[2*i +: 2] = kind[i];
      assign is_cfi_o[i]          = (kind[i] != CFI_NONE);
   end

   fbpd_start_chain #(.SLOTS(SLOTS)) u_chain_a (
      .seed_i  (1'b1),
      .rvc_i   (is_rvc_o),
      .start_o (start_a_o)
   );

   fbpd_start_chain #(.SLOTS(SLOTS)) u_chain_b (
      .seed_i  (1'b0),
      .rvc_i   (is_rvc_o),
      .start_o (start_b_o)
   );

   // Once the two vectors agree on a slot they agree on every later slot
   for (genvar i = 1; i < SLOTS; i++) begin : g_conv
      always_comb begin
         p_converge_r10: assert (start_a_o[i-1] != start_b_o[i-1] ||
                                 start_a_o[i] == start_b_o[i])
            else $error("start vectors diverge again at slot %0d", i);
      end
   end

endmodule

// File: tb/sim_fbpd_predecoder.sv
`timescale 1ns/1ps
module sim_fbpd_predecoder;

   localparam int SLOTS = 16;
   localparam int OFF_W = 64;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [SLOTS:0][15:0]      hw;
   logic [(SLOTS+1)*16-1:0]   frag_i;
   logic [SLOTS*32-1:0]       raw_code_o;
   logic [SLOTS-1:0]          is_rvc_o, is_cfi_o, is_call_o, is_ret_o;
   logic [SLOTS*2-1:0]        cfi_type_o;
   logic [SLOTS*OFF_W-1:0]    tgt_off_o;
   logic [SLOTS-1:0]          start_a_o, start_b_o;

   assign frag_i = hw;

   fbpd_predecoder u0 (
      .frag_i     (frag_i),
      .raw_code_o (raw_code_o),
      .is_rvc_o   (is_rvc_o),
      .cfi_type_o (cfi_type_o),
      .is_cfi_o   (is_cfi_o),
      .is_call_o  (is_call_o),
      .is_ret_o   (is_ret_o),
      .tgt_off_o  (tgt_off_o),
      .start_a_o  (start_a_o),
      .start_b_o  (start_b_o)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic chk(input string req, input string what, input int slot,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s slot %0d: actual=%h expected=%h", req, what, slot, act, exp);
      end
   endtask

   function automatic logic lnk(input logic [4:0] r);
      return (r == 5'd1) || (r == 5'd5);
   endfunction

   // Reference decode written from the requirements
   task automatic ref_slot(input logic [31:0] c, output logic rvc, output logic [1:0] ty,
                           output logic call, output logic ret, output logic [63:0] off);
      logic [12:0] ib;
      logic [20:0] ij;
      logic [8:0]  icb;
      logic [11:0] icj;
      ib  = {c[31], c[7], c[30:25], c[11:8], 1'b0};
      ij  = {c[31], c[19:12], c[20], c[30:21], 1'b0};
      icb = {c[12], c[6:5], c[2], c[11:10], c[4:3], 1'b0};
      icj = {c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
      rvc = (c[1:0] != 2'b11);
      ty = 2'b00; call = 0; ret = 0; off = 64'd0;
      if (!rvc) begin
         if (c[6:0] == 7'b1100011) begin ty = 2'b01; off = {{51{ib[12]}}, ib}; end
         else if (c[6:0] == 7'b1101111) begin
            ty = 2'b10; call = lnk(c[11:7]); off = {{43{ij[20]}}, ij};
         end else if (c[6:0] == 7'b1100111) begin
            ty = 2'b11; call = lnk(c[11:7]); ret = lnk(c[19:15]) && !lnk(c[11:7]);
         end
      end else if (c[1:0] == 2'b01 && (c[15:13] == 3'b101 || c[15:13] == 3'b001)) begin
         ty = 2'b10; call = (c[15:13] == 3'b001); off = {{52{icj[11]}}, icj};
      end else if (c[1:0] == 2'b01 && c[15:14] == 2'b11) begin
         ty = 2'b01; off = {{55{icb[8]}}, icb};
      end else if (c[1:0] == 2'b10 && c[15:13] == 3'b100 && c[6:2] == 0 && c[11:7] != 0) begin
         ty = 2'b11;
         if (c[12]) call = 1'b1;
         else ret = lnk(c[11:7]);
      end
   endtask

   task automatic check_all(input string scen);
      logic rvc, call, ret;
      logic [1:0] ty;
      logic [63:0] off;
      logic [SLOTS-1:0] ea, eb, rv;
      for (int i = 0; i < SLOTS; i++) begin
         ref_slot({hw[i+1], hw[i]}, rvc, ty, call, ret, off);
         rv[i] = rvc;
         chk("R1", {scen, " raw"}, i, 64'(raw_code_o[i*32 +: 32]), 64'({hw[i+1], hw[i]}));
         chk("R2", {scen, " rvc"}, i, 64'(is_rvc_o[i]), 64'(rvc));
         chk(rvc ? "R4" : "R3", {scen, " type"}, i, 64'(cfi_type_o[2*i +: 2]), 64'(ty));
         chk("R3", {scen, " is_cfi"}, i, 64'(is_cfi_o[i]), 64'(ty != 2'b00));
         chk("R5", {scen, " call"}, i, 64'(is_call_o[i]), 64'(call));
         chk("R6", {scen, " ret"}, i, 64'(is_ret_o[i]), 64'(ret));
         chk(rvc ? "R8" : "R7", {scen, " offset"}, i, tgt_off_o[i*OFF_W +: OFF_W], off);
      end
      ea[0] = 1'b1;
      eb[0] = 1'b0;
      for (int i = 1; i < SLOTS; i++) begin
         ea[i] = !(ea[i-1] && !rv[i-1]);
         eb[i] = !(eb[i-1] && !rv[i-1]);
      end
      chk("R9",  {scen, " start_a"}, 0, 64'(start_a_o), 64'(ea));
      chk("R10", {scen, " start_b"}, 0, 64'(start_b_o), 64'(eb));
   endtask

   task automatic apply();
      @(posedge clk);
      @(negedge clk);
   endtask

   // All-zero block: every slot compressed, nothing decodes as a jump
   task automatic t_zero_block();
      hw = '0;
      apply();
      chk("R2", "zero rvc", 0, 64'(is_rvc_o), 64'(16'hFFFF));
      chk("R9", "zero start_a", 0, 64'(start_a_o), 64'(16'hFFFF));
      chk("R10", "zero start_b", 0, 64'(start_b_o), 64'(16'hFFFE));
      check_all("zero");
   endtask

   // Every halfword looks like a 32-bit opening: alternating starts
   task automatic t_all_wide();
      for (int i = 0; i <= SLOTS; i++) hw[i] = 16'h0013;
      apply();
      chk("R9", "wide start_a", 0, 64'(start_a_o), 64'(16'h5555));
      chk("R10", "wide start_b", 0, 64'(start_b_o), 64'(16'hAAAA));
      chk("R1", "wide raw last", 15, 64'(raw_code_o[15*32 +: 32]), 64'(32'h0013_0013));
      check_all("wide");
   endtask

   task automatic t_rvi_cfi();
      logic [31:0] r;
      for (int i = 0; i <= SLOTS; i++) hw[i] = 16'(i * 16'h1357);
      hw[0] = 16'hF0EF; hw[1] = 16'hFFDF;          // jal x1, -4
      r = $urandom; {hw[3], hw[2]} = {r[31:7], 7'b1100011};
      r = $urandom; {hw[5], hw[4]} = {r[31:7], 7'b1101111};
      r = $urandom; {hw[8], hw[7]} = {r[31:7], 7'b1100111};
      r = $urandom; {hw[16], hw[15]} = {r[31:7], 7'b1100011};
      apply();
      chk("R3", "jal type", 0, 64'(cfi_type_o[1:0]), 64'(2'b10));
      chk("R5", "jal x1 call", 0, 64'(is_call_o[0]), 64'd1);
      chk("R7", "jal -4 offset", 0, tgt_off_o[63:0], 64'hFFFF_FFFF_FFFF_FFFC);
      check_all("rvi_cfi");
   endtask

   task automatic t_rvc_cfi();
      logic [31:0] r;
      for (int i = 0; i <= SLOTS; i++) hw[i] = 16'h4501;   // c.li: plain compressed
      hw[0] = 16'hBFFD;                              // c.j -2
      hw[1] = 16'h8082;                              // c.jr x1
      hw[2] = 16'h9282;                              // c.jalr x5
      hw[3] = 16'h8002;                              // reserved register jump
      hw[4] = 16'h808A;                              // c.mv x1, x2
      r = $urandom; hw[5] = {3'b110, r[12:2], 2'b01};
      r = $urandom; hw[6] = {3'b111, r[12:2], 2'b01};
      r = $urandom; hw[7] = {3'b001, r[12:2], 2'b01};
      r = $urandom; hw[8] = {3'b101, r[12:2], 2'b01};
      hw[9] = 16'h8282;                              // c.jr x5
      hw[10] = 16'h8302;                             // c.jr x6
      apply();
      chk("R8", "c.j -2 offset", 0, tgt_off_o[63:0], 64'hFFFF_FFFF_FFFF_FFFE);
      chk("R6", "c.jr x1 ret", 1, 64'(is_ret_o[1]), 64'd1);
      chk("R5", "c.jalr call", 2, 64'(is_call_o[2]), 64'd1);
      chk("R4", "reserved jr type", 3, 64'(cfi_type_o[7:6]), 64'd0);
      chk("R4", "c.mv type", 4, 64'(cfi_type_o[9:8]), 64'd0);
      chk("R5", "c.jal call", 7, 64'(is_call_o[7]), 64'd1);
      chk("R6", "c.jr x6 no ret", 10, 64'(is_ret_o[10]), 64'd0);
      check_all("rvc_cfi");
   endtask

   task automatic t_call_ret();
      for (int i = 0; i <= SLOTS; i++) hw[i] = 16'h0001;
      {hw[1], hw[0]} = 32'h0000_8067;               // jalr x0, 0(x1): ret
      {hw[3], hw[2]} = 32'h0002_80E7;               // jalr x1, 0(x5): call
      {hw[5], hw[4]} = 32'h0000_82E7;               // jalr x5, 0(x1): call only
      {hw[7], hw[6]} = 32'h0000_02EF;               // jal x5: call
      {hw[9], hw[8]} = 32'h0000_006F;               // jal x0: plain jump
      {hw[11], hw[10]} = 32'h0001_0067;             // jalr x0, 0(x2): neither
      {hw[13], hw[12]} = 32'h0002_8067;             // jalr x0, 0(x5): ret
      apply();
      chk("R6", "jalr x0,(x1)", 0, 64'(is_ret_o[0]), 64'd1);
      chk("R5", "jalr x1,(x5)", 2, 64'(is_call_o[2]), 64'd1);
      chk("R6", "jalr x1,(x5) no ret", 2, 64'(is_ret_o[2]), 64'd0);
      chk("R6", "jalr x5,(x1) no ret", 4, 64'(is_ret_o[4]), 64'd0);
      chk("R5", "jal x5", 6, 64'(is_call_o[6]), 64'd1);
      chk("R5", "jal x0", 8, 64'(is_call_o[8]), 64'd0);
      chk("R6", "jalr x0,(x2)", 10, 64'(is_ret_o[10] | is_call_o[10]), 64'd0);
      chk("R7", "jalr offset", 12, tgt_off_o[12*OFF_W +: OFF_W], 64'd0);
      check_all("call_ret");
   endtask

   task automatic t_mixed_starts();
      for (int i = 0; i <= SLOTS; i++) hw[i] = (i % 3 == 0) ? 16'h0013 : 16'h0001;
      hw[15] = 16'h0017;                             // last slot opens a 32-bit code
      apply();
      check_all("mixed");
   endtask

   task automatic t_random();
      for (int n = 0; n < 200; n++) begin
         for (int i = 0; i <= SLOTS; i++) hw[i] = 16'($urandom);
         apply();
         check_all("random");
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      hw = '0;
      repeat (2) @(posedge clk);
      t_zero_block();
      t_all_wide();
      t_rvi_cfi();
      t_rvc_cfi();
      t_call_ret();
      t_mixed_starts();
      t_random();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_run();
      end
   end

endmodule